// File: doc/BRIEF.md
# Banked Edge/Level Interrupt Aggregator

This block gathers interrupt requests from a set of peripherals and presents them to a host processor as one combined interrupt line. The sources are grouped into banks of eight. Each bank has a status register that records requests and a mask register that enables them. Every request input passes through a synchroniser first. Most sources latch a rising edge into their status bit. One designated source is level-sensitive instead: its status bit shows the synchronised input level directly.

The host services the line with a small byte-wide register port. It reads a bank's status register to learn which requests are waiting. That same read acknowledges the edge-latched bits it returned, so no separate acknowledge register is needed. An edge that arrives while its source is masked is discarded. It is not replayed when the mask is set later. The combined output is a registered OR of all enabled pending bits, so a host that detects rising edges sees a fresh edge for every new batch of requests.

Top module: `irq_bank_agg`

## Requirements
- R1: After reset, every mask register reads 0x00, every edge status bit is 0, `irq_out` is 0 and `bus_rdata` is 0x00.
- R2: Register map for bank b: status at byte address 2b and mask at address 2b+1. Bank 0 holds sources 0–7, bank 1 holds 8–15 and bank 2 holds 16–23, with source s at bit s mod 8. A read asserted at a clock edge puts its data on `bus_rdata` after that edge and holds it for one cycle. Otherwise `bus_rdata` is 0x00. Addresses 6 and 7 read 0x00. A mask bit of 1 enables its source.
- R3: A write to a status address changes no register.
- R4: A rising edge on an edge-sensitive source whose mask bit is 1 sets its status bit at the third clock edge after the input rises. Two clock edges are spent in synchronisation and one in capture.
- R5: A rising edge that arrives while its mask bit is 0 is lost. Setting the mask bit afterwards does not set the status bit.
- R6: A status read returns the bank's status byte and clears the edge status bits it returned. A second read right after it returns 0x00 for those bits.
- R7: An edge captured at the same clock edge as a status read of its bank is not returned by that read. It stays pending and is returned by the next read.
- R8: Source 0 (parameter `LEVEL_SRC`) is level-sensitive. Its status bit follows the synchronised input regardless of the mask, and a status read does not clear it.
- R9: `irq_out` is high one clock after any bank has a status bit AND mask bit both set, and low one clock after no bank does. Clearing the mask of a set status bit therefore drops `irq_out` while the status bit remains readable.
- R10: When a status read clears the last pending bit, `irq_out` falls one clock after that read.
- R11: A status read of one bank leaves the status bits of the other banks unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_in | input | 24 | Asynchronous request inputs, one per source |
| bus_addr | input | 3 | Register byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| irq_out | output | 1 | Combined interrupt line, registered |

## Verification
Some properties are checked on every cycle. Masks reset to zero, and masks hold unless their own address is written. An edge status bit only rises on a source whose mask was already set. The read bus returns to zero when idle. `irq_out` follows the enabled pending set with one clock of delay. Other behaviours depend on sequences of stimulus, so only the bench scenarios can show them:
- the three-edge capture latency;
- the loss of a masked edge after the mask is set;
- a capture landing in the same cycle as a read;
- the level source surviving reads;
- the fall of `irq_out` after the emptying read.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {
    REG_STATUS = 1'b0,
    REG_MASK   = 1'b1
  } reg_kind_e;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int W      = 24,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] chain [STAGES];

  genvar s;
  generate
    for (s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain[s] <= '0;
        else if (s == 0) chain[s] <= async_in;
        else chain[s] <= chain[(s == 0) ? 0 : s-1];
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/irq_bank.sv
module irq_bank #(
  parameter int   BANK_W    = 8,
  parameter bit   LEVEL_EN  = 1'b0,
  parameter int   LEVEL_BIT = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [BANK_W-1:0] sync_in,
  input  logic              mask_we,
  input  logic [BANK_W-1:0] wdata,
  input  logic              stat_rd,
  output logic [BANK_W-1:0] status,
  output logic [BANK_W-1:0] mask
);
  localparam logic [BANK_W-1:0] LVL_SEL =
    LEVEL_EN ? (BANK_W'(1) << LEVEL_BIT) : '0;

  logic [BANK_W-1:0] prev_q;
  logic [BANK_W-1:0] edge_q;
  logic [BANK_W-1:0] rise_hit;

  // rising edges accepted only while the mask bit is set at that moment
  assign rise_hit = sync_in & ~prev_q & mask & ~LVL_SEL;

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= '0;
      edge_q <= '0;
      mask   <= '0;
    end else begin
      prev_q <= sync_in;
      // a read clears what it returned; a same-cycle capture survives
      edge_q <= (stat_rd ? '0 : edge_q) | rise_hit;
      if (mask_we) mask <= wdata;
    end
  end

  assign status = (edge_q & ~LVL_SEL) | (sync_in & LVL_SEL);
endmodule

// File: rtl/irq_bank_agg.sv
module irq_bank_agg #(
  parameter int NUM_BANKS   = 3,
  parameter int BANK_W      = 8,
  parameter int ADDR_W      = 3,
  parameter int SYNC_STAGES = 2,
  parameter int LEVEL_SRC   = 0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_BANKS*BANK_W-1:0] req_in,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  logic                        bus_wr,
  input  logic [BANK_W-1:0]           bus_wdata,
  input  logic                        bus_rd,
  output logic [BANK_W-1:0]           bus_rdata,
  output logic                        irq_out
);
  import irq_agg_pkg::*;

  localparam int NSRC      = NUM_BANKS * BANK_W;
  localparam int LVL_BANK  = LEVEL_SRC / BANK_W;
  localparam int LVL_BIT   = LEVEL_SRC % BANK_W;

  logic [NSRC-1:0] req_sync;
  logic [NSRC-1:0] status_all;
  logic [NSRC-1:0] mask_all;
  logic [NUM_BANKS-1:0] bank_hit;
  reg_kind_e       kind;

  assign kind = reg_kind_e'(bus_addr[0]);

  irq_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .async_in (req_in),
    .sync_out (req_sync)
  );

  genvar b;
  generate
    for (b = 0; b < NUM_BANKS; b++) begin : g_bank
      assign bank_hit[b] = (bus_addr[ADDR_W-1:1] == (ADDR_W-1)'(b));

      irq_bank #(
        .BANK_W    (BANK_W),
        .LEVEL_EN  (LVL_BANK == b),
        .LEVEL_BIT (LVL_BIT)
      ) u_bank (
        .clk     (clk),
        .rst     (rst),
        .sync_in (req_sync[b*BANK_W +: BANK_W]),
        .mask_we (bus_wr && bank_hit[b] && kind == REG_MASK),
        .wdata   (bus_wdata),
        .stat_rd (bus_rd && bank_hit[b] && kind == REG_STATUS),
        .status  (status_all[b*BANK_W +: BANK_W]),
        .mask    (mask_all[b*BANK_W +: BANK_W])
      );
    end
  endgenerate

  logic [BANK_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_BANKS; i++) begin
      if (bank_hit[i])
        rd_mux = (kind == REG_MASK) ? mask_all[i*BANK_W +: BANK_W]
                                    : status_all[i*BANK_W +: BANK_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      irq_out   <= 1'b0;
    end else begin
      bus_rdata <= bus_rd ? rd_mux : '0;
      irq_out   <= |(status_all & mask_all);
    end
  end
endmodule

module irq_bank_agg_chk #(
  parameter int NSRC      = 24,
  parameter int BANK_W    = 8,
  parameter int NUM_BANKS = 3,
  parameter int ADDR_W    = 3,
  parameter int LEVEL_SRC = 0
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [BANK_W-1:0] bus_rdata,
  input logic              irq_out,
  input logic [NSRC-1:0]   status_all,
  input logic [NSRC-1:0]   mask_all
);
  localparam logic [NSRC-1:0] EDGE_SEL = ~(NSRC'(1) << LEVEL_SRC);

  // R1: masks come out of reset cleared
  p_mask_reset_r1: assert property (@(posedge clk) rst |=> (mask_all == '0));

  // R2: read bus is zero when no read was issued
  p_rdata_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));

  // R2/R3: masks change only on a write to a mask address
  p_mask_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_addr[0] && (int'(bus_addr) < 2*NUM_BANKS)) |=> $stable(mask_all));

  // R5: an edge status bit only rises where the mask was already set
  p_masked_lost_r5: assert property (@(posedge clk) disable iff (rst)
    ((status_all & ~$past(status_all) & ~$past(mask_all) & EDGE_SEL) == '0));

  // R9: combined line follows the enabled pending set
  p_irq_high_r9: assert property (@(posedge clk) disable iff (rst)
    (|(status_all & mask_all)) |=> irq_out);
  p_irq_low_r9: assert property (@(posedge clk) disable iff (rst)
    !(|(status_all & mask_all)) |=> !irq_out);
endmodule

bind irq_bank_agg irq_bank_agg_chk #(
  .NSRC(NUM_BANKS*BANK_W), .BANK_W(BANK_W), .NUM_BANKS(NUM_BANKS),
  .ADDR_W(ADDR_W), .LEVEL_SRC(LEVEL_SRC)
) u_chk (
  .clk(clk), .rst(rst), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_out(irq_out),
  .status_all(status_all), .mask_all(mask_all)
);

// File: tb/irq_bank_agg_bench.sv
module irq_bank_agg_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] req_in = '0;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic        irq_out;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  logic rd_issued = 1'b0;
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  irq_bank_agg u_irq_bank_agg (
    .clk(clk), .rst(rst), .req_in(req_in), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd),
    .bus_rdata(bus_rdata), .irq_out(irq_out)
  );

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles <= cycles + 1;
    rd_issued <= bus_rd;
    if (cycles > 20000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=done");
      finish_run();
    end
  end

  // monitor: compare read data against the scoreboard
  always @(negedge clk) begin
    if (rd_issued) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL unexpected read: actual=%02h expected=none", bus_rdata);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (bus_rdata !== e) begin
          errors++;
          $display("FAIL %s: actual=%02h expected=%02h", t, bus_rdata, e);
        end
      end
    end
  end

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
    bus_addr = a; bus_rd = 1'b1;
    exp_q.push_back(e); tag_q.push_back(t);
    tick();
    bus_rd = 1'b0;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    tick();
    bus_wr = 1'b0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    checks++;
    if (irq_out !== e) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b", t, irq_out, e);
    end
  endtask

  task automatic pulse(input int s);
    req_in[s] = 1'b1; tick(3);
    req_in[s] = 1'b0; tick(3);
  endtask

  initial begin
    tick(3);
    rst = 1'b0;
    tick();
    // R1 reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(3'd1, 8'h00, "R1 mask0 reset");
    rd(3'd3, 8'h00, "R1 mask1 reset");
    rd(3'd5, 8'h00, "R1 mask2 reset");
    rd(3'd2, 8'h00, "R1 status1 reset");
    // R2 mask readback and unused address
    wr(3'd1, 8'hA5); wr(3'd3, 8'h3C); wr(3'd5, 8'h81);
    rd(3'd1, 8'hA5, "R2 mask0");
    rd(3'd3, 8'h3C, "R2 mask1");
    rd(3'd5, 8'h81, "R2 mask2");
    rd(3'd6, 8'h00, "R2 unused addr");
    // R3 status write ignored
    wr(3'd0, 8'hFF); wr(3'd2, 8'hFF);
    rd(3'd0, 8'h00, "R3 status0 unchanged");
    rd(3'd2, 8'h00, "R3 status1 unchanged");
    rd(3'd3, 8'h3C, "R3 mask1 unchanged");
    wr(3'd1, 8'h00); wr(3'd3, 8'h00); wr(3'd5, 8'h00);
    tick(2);
    // R4/R7 latency and same-cycle capture (source 5)
    wr(3'd1, 8'h20);
    req_in[5] = 1'b1;
    tick(2);
    rd(3'd0, 8'h00, "R7 capture during read not returned");
    rd(3'd0, 8'h20, "R4 edge captured on third edge");
    rd(3'd0, 8'h00, "R6 read cleared bit");
    req_in[5] = 1'b0; tick(3);
    // R5 masked edge lost
    pulse(16);
    wr(3'd5, 8'h01); tick(3);
    rd(3'd4, 8'h00, "R5 masked edge not replayed");
    chk_irq(1'b0, "R5 no irq");
    // R9/R10 combined line (source 11)
    wr(3'd3, 8'h08);
    pulse(11);
    chk_irq(1'b1, "R9 irq on enabled pending");
    rd(3'd2, 8'h08, "R6 status1 read");
    tick();
    chk_irq(1'b0, "R10 irq drops after emptying read");
    pulse(11);
    chk_irq(1'b1, "R10 irq reasserts for new batch");
    wr(3'd3, 8'h00); tick();
    chk_irq(1'b0, "R9 irq low when masked");
    rd(3'd2, 8'h08, "R9 status kept while masked");
    // R11 bank independence (sources 2 and 9)
    wr(3'd1, 8'h04); wr(3'd3, 8'h02);
    pulse(2); pulse(9);
    rd(3'd0, 8'h04, "R11 bank0 read");
    rd(3'd2, 8'h02, "R11 bank1 untouched");
    // R8 level source 0, even while masked
    wr(3'd1, 8'h00);
    req_in[0] = 1'b1; tick(4);
    rd(3'd0, 8'h01, "R8 level bit set");
    rd(3'd0, 8'h01, "R8 level bit survives read");
    chk_irq(1'b0, "R8 masked level no irq");
    wr(3'd1, 8'h01); tick(2);
    chk_irq(1'b1, "R8 enabled level irq");
    req_in[0] = 1'b0; tick(4);
    rd(3'd0, 8'h00, "R8 level bit follows input low");
    chk_irq(1'b0, "R8 irq drops with level");
    tick(3);
    if (exp_q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: actual=%0d left expected=0", exp_q.size());
    end
    finish_run();
  end
endmodule